// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A fetch stage presents the branch address on the lookup port. The block combines that address with a register of recent branch outcomes and uses the result to pick one entry in a table of two-bit saturating counters. The top bit of that counter is the guess. The lookup port also returns the outcome history it used. The fetch stage keeps that value with the branch.

When the branch resolves, the pipeline sends back the branch address, the history it carried, and the actual outcome. The block finds the same table entry again from those values, not from the current history, which may have moved on. It moves that counter one step toward the outcome. It then shifts the outcome into the history register.

The lookup is combinational against registered state. A lookup in the same cycle as an update therefore sees the table and history as they were before that update is written.

Top module: `gshare_predictor`

## Requirements
- R1: The lookup entry index is `lkp_pc[IDX_W+1:2]` XOR the current history, and `lkp_taken` is bit 1 of that entry's counter (1 = taken).
- R2: After reset the history is all zeros and every counter holds 2'b01, so every lookup predicts not-taken.
- R3: An update with `upd_taken`=1 adds one to the selected counter, saturating at 2'b11.
- R4: An update with `upd_taken`=0 subtracts one from the selected counter, saturating at 2'b00.
- R5: The update entry index is `upd_pc[IDX_W+1:2]` XOR `upd_hist`, independent of the current history.
- R6: Each update shifts the history left by one, places `upd_taken` in bit 0 and discards the oldest bit.
- R7: A lookup in the same cycle as an update returns the prediction from the counter value before that update.
- R8: `lkp_hist` always shows the history value that the current lookup uses.
- R9: While `upd_valid` is low, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lkp_pc | input | PC_W | Fetch address to predict |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| lkp_hist | output | IDX_W | History used by this lookup |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | IDX_W | History captured when that branch was looked up |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The bench drives one counter into both saturation limits and then reads back every table entry. A counter that wraps instead of saturating would show up there as a flipped prediction. Random updates often carry a stale history value, so a design that indexed training with the live history would corrupt the wrong entries and miss later predictions. Lookups that hit the entry being trained in the same cycle catch a design that forwards the new counter value. The bench compares the history after every update, which exposes a shift in the wrong direction or a shift on idle cycles.

// File: rtl/gshare_pkg.sv
// Shared types and counter arithmetic for the history-indexed predictor.
// Assumes counters are two bits wide and saturate at both ends.
package gshare_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_t;

    // Next counter value after one resolved outcome, saturating at both limits.
    function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != CTR_STRONG_T) begin
            nxt = ctr_t'(cur + 2'd1);
        end else if (!taken && cur != CTR_STRONG_NT) begin
            nxt = ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gshare_index.sv
// Forms a table index by XORing an address subfield with a history value.
// Assumes PC_W >= IDX_W + PC_SKIP; the low PC_SKIP address bits are ignored.
module gshare_index #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 10,
    parameter int PC_SKIP = 2
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IDX_W-1:0] hist,
    output logic [IDX_W-1:0] idx
);

    // Bitwise hash of the address field and the history.
    always_comb begin
        idx = pc[PC_SKIP +: IDX_W] ^ hist;
    end

endmodule

// File: rtl/gshare_history.sv
// Global outcome shift register; the newest outcome enters at bit 0.
// Assumes only resolved outcomes are shifted in (no speculative update).
module gshare_history #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [IDX_W-1:0] hist
);

    // Clear on reset, otherwise shift one outcome in per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[IDX_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/gshare_pht.sv
// Table of two-bit counters with one combinational read and one trained write.
// Assumes a write becomes visible to reads only after the clock edge.
module gshare_pht
    import gshare_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_q [DEPTH];

    // Read the selected counter from registered state.
    always_comb begin
        rd_ctr = ctr_q[rd_idx];
    end

    // Reset every entry to weakly not-taken; train one entry per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_train(ctr_q[wr_idx], wr_taken);
        end
    end

endmodule

// File: rtl/gshare_predictor.sv
// Branch direction predictor indexed by address XOR global history.
// Assumes the caller returns the lookup-time history with each update.
module gshare_predictor
    import gshare_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lkp_pc,
    output logic             lkp_taken,
    output logic [IDX_W-1:0] lkp_hist,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [IDX_W-1:0] upd_hist,
    input  logic             upd_taken
);

    localparam int PC_SKIP = 2;

    logic [IDX_W-1:0] ghr;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    ctr_t             rd_ctr;

    gshare_history #(.IDX_W(IDX_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist     (ghr)
    );

    gshare_index #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_SKIP(PC_SKIP)) u_rd_index (
        .pc   (lkp_pc),
        .hist (ghr),
        .idx  (rd_idx)
    );

    gshare_index #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_SKIP(PC_SKIP)) u_wr_index (
        .pc   (upd_pc),
        .hist (upd_hist),
        .idx  (wr_idx)
    );

    gshare_pht #(.IDX_W(IDX_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken)
    );

    // Prediction is the counter's upper bit; history is exposed for return.
    always_comb begin
        lkp_taken = rd_ctr[1];
        lkp_hist  = ghr;
    end

endmodule

// File: rtl/gshare_predictor_chk.sv
// Port-level properties of the predictor, bound onto every instance.
module gshare_predictor_chk #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lkp_pc,
    input logic             lkp_taken,
    input logic [IDX_W-1:0] lkp_hist,
    input logic             upd_valid,
    input logic [PC_W-1:0]  upd_pc,
    input logic [IDX_W-1:0] upd_hist,
    input logic             upd_taken
);

    assert_reset_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!lkp_taken && lkp_hist == '0));

    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> lkp_hist == {$past(lkp_hist[IDX_W-2:0]), $past(upd_taken)});

    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(lkp_hist));

    assert_pred_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(lkp_pc) -> $stable(lkp_taken)));

endmodule

bind gshare_predictor gshare_predictor_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_pc    (lkp_pc),
    .lkp_taken (lkp_taken),
    .lkp_hist  (lkp_hist),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_hist  (upd_hist),
    .upd_taken (upd_taken)
);

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb;

    localparam int PC_W  = 12;
    localparam int IDX_W = 4;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  lkp_pc = '0;
    logic             lkp_taken;
    logic [IDX_W-1:0] lkp_hist;
    logic             upd_valid = 1'b0;
    logic [PC_W-1:0]  upd_pc = '0;
    logic [IDX_W-1:0] upd_hist = '0;
    logic             upd_taken = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int               m_ctr [DEPTH];
    logic [IDX_W-1:0] m_hist;
    logic [31:0]      rng = 32'h1234_5678;

    always #4 clk = ~clk;

    gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lkp_pc    (lkp_pc),
        .lkp_taken (lkp_taken),
        .lkp_hist  (lkp_hist),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_hist  (upd_hist),
        .upd_taken (upd_taken)
    );

    function automatic int m_idx(input logic [PC_W-1:0] pc, input logic [IDX_W-1:0] h);
        return int'(pc[IDX_W+1:2] ^ h);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    // One cycle: drive at the falling edge, check outputs, then commit the model.
    task automatic step(input logic [PC_W-1:0] pc, input logic uv, input logic [PC_W-1:0] upc,
                        input logic [IDX_W-1:0] uh, input logic ut, input string req);
        int e;
        @(negedge clk);
        lkp_pc = pc; upd_valid = uv; upd_pc = upc; upd_hist = uh; upd_taken = ut;
        #1;
        e = m_ctr[m_idx(pc, m_hist)] >> 1;
        check(lkp_taken == e[0], req, int'(lkp_taken), e);
        check(lkp_hist == m_hist, "R8 history", int'(lkp_hist), int'(m_hist));
        @(posedge clk);
        if (uv) begin
            e = m_idx(upc, uh);
            if (ut && m_ctr[e] < 3) m_ctr[e]++;
            if (!ut && m_ctr[e] > 0) m_ctr[e]--;
            m_hist = {m_hist[IDX_W-2:0], ut};
        end
    endtask

    task automatic sweep(input string req);
        for (int j = 0; j < DEPTH; j++) begin
            step(PC_W'(j << 2), 1'b0, '0, '0, 1'b0, req);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_ctr[i] = 1;
        m_hist = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every entry weakly not-taken, history zero.
        sweep("R2 reset");

        // R3 + R5: saturate one entry high using a history unlike the live one.
        for (int k = 0; k < 5; k++) step(12'h010, 1'b1, 12'h010, 4'h9, 1'b1, "R3 R7 taken");
        sweep("R3 saturate high");

        // R4: drive it down past zero.
        for (int k = 0; k < 6; k++) step(12'h010, 1'b1, 12'h010, 4'h9, 1'b0, "R4 R7 not-taken");
        sweep("R4 saturate low");

        // R9: idle cycles leave everything unchanged.
        sweep("R9 idle");

        // R1, R5, R6, R7: random traffic, often with stale histories and colliding indices.
        for (int k = 0; k < 3000; k++) begin
            logic [PC_W-1:0]  lpc, upc;
            logic [IDX_W-1:0] uh;
            next_rng();
            lpc = rng[PC_W-1:0];
            upc = rng[1] ? lpc : rng[27:16];
            uh  = rng[2] ? m_hist : rng[31:28];
            step(lpc, rng[3] | rng[4], upc, uh, rng[5] | rng[6] & rng[7], "R1 R5 R6 R7 random");
        end
        sweep("R1 final table");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule